// File: doc/BRIEF.md
# Exception Entry and Status Controller

This block holds the control-register state that a small 32-bit RISC core uses when it takes an exception. It keeps four registers: status, cause, exception PC and processor ID. It loads their reset values and drives the fetch address that the core starts from after reset.

When the pipeline raises an exception request, the block records three things:
- the exception code and the branch-delay indication in the cause register;
- the address of the faulting instruction, or of its branch, in the exception-PC register;
- a pushed copy of the mode/interrupt-enable stack in the low status bits.

In the same step it redirects fetch to a boot-ROM or RAM handler address, and which one depends on a status bit. The block also raises an interrupt exception on its own when a pending line is enabled. A return pulse pops the mode/enable stack. Move-to and move-from instructions reach the registers through a simple write port and a read port.

Top module: `exc_status_ctrl`

## Requirements
- R1: After reset with `ram_vec_cfg` low, `fetch_pc` is 0xBFC00000, `redirect` is 0, status reads 0x10600000, processor ID reads 0x00000002, and cause and exception PC read 0.
- R2: After reset with `ram_vec_cfg` high, status reads 0x50200000. This value has bit 30 set and bit 22 cleared.
- R3: On an exception entry, the cause register becomes the following, with every other bit zero:
  - bits 31:30 hold `exc_bd`;
  - bits 10:8 keep their old value;
  - bits 6:2 hold the exception code. The code is `exc_code` for a request and 0 for an interrupt.
- R4: On entry, the exception PC takes `exc_pc` when `exc_bd` is 0. Otherwise it takes `exc_pc` minus 4.
- R5: On entry, `fetch_pc` becomes 0xBFC00180 if old status bit 22 is set, and 0x80000080 otherwise. `redirect` is high for exactly the cycle after each entry.
- R6: On entry, status bits 5:0 become the old bits 3:0 shifted left by two, with zeros in bits 1:0. Bits 31:6 are unchanged.
- R7: A `rfe` pulse without an entry and without a status write sets status bits 3:0 to the old bits 5:2. Bits 31:4 are left unchanged.
- R8: `irq_take` is high when status bit 0, status bit 10 and `irq_pending` are all high. If `exc_req` is low in that cycle, an entry with code 0 is taken.
- R9: In a cycle without an entry, cause bit 10 takes the `irq_pending` level. A cause write changes only bits 9:8.
- R10: An entry overrides `rfe` and every register write in the same cycle. A status write overrides `rfe`.
- R11: `rd_sel` chooses the register on `rd_data`: 0 is status, 1 is cause, 2 is exception PC, 3 is processor ID. Writes with `wr_sel` 2 or 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_vec_cfg | input | 1 | Reset option: enable coprocessor 2 and select the RAM vector |
| exc_req | input | 1 | Exception request from the pipeline |
| exc_code | input | 5 | Exception code (0 interrupt, 8 syscall, 9 breakpoint) |
| exc_bd | input | 2 | Branch-delay indication of the faulting instruction |
| exc_pc | input | 32 | Address of the faulting instruction |
| rfe | input | 1 | Return-from-exception pulse |
| irq_pending | input | 1 | Pending hardware interrupt line |
| wr_en | input | 1 | Register write strobe (move-to) |
| wr_sel | input | 2 | Register written |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register read (move-from) |
| rd_data | output | 32 | Read data |
| irq_take | output | 1 | Enabled interrupt present this cycle |
| redirect | output | 1 | Fetch redirected in the previous cycle |
| fetch_pc | output | 32 | Next fetch address |

## Verification
Exception entry can fall in the same cycle as either of two other operations: a return pop, or a move-to write of status or cause. The random phase drives all three strobes independently, so these collisions occur many times. Directed cycles also force each pairing on purpose. Each collision is judged by reading every register afterwards and comparing it with a bench model in which the entry wins. In that model the pushed stack appears in status, the return is discarded, and the written data never shows up.

// File: rtl/exc_status_ctrl.sv
module exc_status_ctrl #(
  parameter logic [31:0] RESET_PC  = 32'hBFC0_0000,
  parameter logic [31:0] ROM_VEC   = 32'hBFC0_0180,
  parameter logic [31:0] RAM_VEC   = 32'h8000_0080,
  parameter logic [31:0] SR_RESET  = 32'h1060_0000,
  parameter logic [31:0] ID_VALUE  = 32'h0000_0002
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ram_vec_cfg,
  input  logic        exc_req,
  input  logic [4:0]  exc_code,
  input  logic [1:0]  exc_bd,
  input  logic [31:0] exc_pc,
  input  logic        rfe,
  input  logic        irq_pending,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        irq_take,
  output logic        redirect,
  output logic [31:0] fetch_pc
);

  logic [31:0] sr_q, cause_q, epc_q;
  logic        take;
  logic [4:0]  code;
  logic        wr_sr, wr_cause;

  assign irq_take = sr_q[0] & sr_q[10] & irq_pending;
  assign take     = exc_req | irq_take;
  assign code     = exc_req ? exc_code : 5'd0;
  assign wr_sr    = wr_en && (wr_sel == 2'd0);
  assign wr_cause = wr_en && (wr_sel == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= ram_vec_cfg ? ((SR_RESET | 32'h4000_0000) & ~32'h0040_0000) : SR_RESET;
      cause_q  <= '0;
      epc_q    <= '0;
      fetch_pc <= RESET_PC;
      redirect <= 1'b0;
    end else if (take) begin
      cause_q  <= {exc_bd, 19'd0, cause_q[10:8], 1'b0, code, 2'b00};
      epc_q    <= (exc_bd != 2'd0) ? exc_pc - 32'd4 : exc_pc;
      fetch_pc <= sr_q[22] ? ROM_VEC : RAM_VEC;
      sr_q     <= {sr_q[31:6], sr_q[3:0], 2'b00};
      redirect <= 1'b1;
    end else begin
      redirect <= 1'b0;
      if (wr_sr)
        sr_q <= wr_data;
      else if (rfe)
        sr_q <= {sr_q[31:4], sr_q[5:2]};
      cause_q[10] <= irq_pending;
      if (wr_cause)
        cause_q[9:8] <= wr_data[9:8];
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = sr_q;
      2'd1:    rd_data = cause_q;
      2'd2:    rd_data = epc_q;
      default: rd_data = ID_VALUE;
    endcase
  end

  // R3
  cause_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cause_q[31:30] == $past(exc_bd)) && (cause_q[10:8] == $past(cause_q[10:8]))
             && (cause_q[29:11] == 19'd0) && (cause_q[7] == 1'b0) && (cause_q[1:0] == 2'b00));

  // R4
  epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> epc_q == (($past(exc_bd) != 2'd0) ? $past(exc_pc) - 32'd4 : $past(exc_pc)));

  // R5
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> redirect && (fetch_pc == ($past(sr_q[22]) ? ROM_VEC : RAM_VEC)));

  // R5
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !redirect);

  // R6
  stack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (sr_q[5:0] == {$past(sr_q[3:0]), 2'b00}) && (sr_q[31:6] == $past(sr_q[31:6])));

  // R7
  stack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !take && !wr_sr) |=> (sr_q[3:0] == $past(sr_q[5:2])) && $stable(sr_q[31:4]));

  // R8
  irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !exc_req) |=> cause_q[6:2] == 5'd0);

  // R10
  write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && wr_cause) |=> $stable(cause_q[9:8]));

endmodule

// File: tb/sim_exc_status_ctrl.sv
module sim_exc_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ram_vec_cfg = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [1:0]  exc_bd = '0;
  logic [31:0] exc_pc = '0;
  logic        rfe = 1'b0;
  logic        irq_pending = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_take, redirect;
  logic [31:0] fetch_pc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_sr, m_cause, m_epc, m_fpc;
  logic        m_redir;

  exc_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ram_vec_cfg(ram_vec_cfg), .exc_req(exc_req),
    .exc_code(exc_code), .exc_bd(exc_bd), .exc_pc(exc_pc), .rfe(rfe),
    .irq_pending(irq_pending), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_take(irq_take), .redirect(redirect),
    .fetch_pc(fetch_pc)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_of(input logic [31:0] sr);
    return sr[22] ? 32'hBFC0_0180 : 32'h8000_0080;
  endfunction

  task automatic check_all(input string req);
    for (int s = 0; s < 4; s++) begin
      rd_sel = s[1:0];
      #1;
      case (s)
        0: chk({req, " R11 status"}, rd_data, m_sr);
        1: chk({req, " R11 cause"}, rd_data, m_cause);
        2: chk({req, " R11 epc"}, rd_data, m_epc);
        default: chk({req, " R11 id"}, rd_data, 32'h2);
      endcase
    end
    chk({req, " R5 fetch_pc"}, fetch_pc, m_fpc);
    chk({req, " R5 redirect"}, {31'd0, redirect}, {31'd0, m_redir});
  endtask

  task automatic do_reset(input logic cfg);
    @(negedge clk);
    ram_vec_cfg = cfg;
    rst_n = 1'b0;
    exc_req = 0; rfe = 0; wr_en = 0; irq_pending = 0;
    @(negedge clk);
    rst_n = 1'b1;
    m_sr = cfg ? 32'h5020_0000 : 32'h1060_0000;
    m_cause = '0; m_epc = '0; m_fpc = 32'hBFC0_0000; m_redir = 1'b0;
    #2;
    check_all(cfg ? "R2" : "R1");
  endtask

  task automatic step(input string req, input logic rq, input logic [4:0] cd,
                      input logic [1:0] bd, input logic [31:0] pc, input logic rt,
                      input logic irq, input logic we, input logic [1:0] ws,
                      input logic [31:0] wd);
    logic ix, tk;
    @(negedge clk);
    exc_req = rq; exc_code = cd; exc_bd = bd; exc_pc = pc; rfe = rt;
    irq_pending = irq; wr_en = we; wr_sel = ws; wr_data = wd;
    #1;
    ix = m_sr[0] & m_sr[10] & irq;
    chk({req, " R8 irq_take"}, {31'd0, irq_take}, {31'd0, ix});
    tk = rq | ix;
    @(posedge clk);
    if (tk) begin
      m_cause = {bd, 19'd0, m_cause[10:8], 1'b0, (rq ? cd : 5'd0), 2'b00};
      m_epc   = (bd != 2'd0) ? pc - 32'd4 : pc;
      m_fpc   = vec_of(m_sr);
      m_sr    = {m_sr[31:6], m_sr[3:0], 2'b00};
      m_redir = 1'b1;
    end else begin
      m_redir = 1'b0;
      if (we && ws == 2'd0) m_sr = wd;
      else if (rt) m_sr = {m_sr[31:4], m_sr[5:2]};
      m_cause[10] = irq;
      if (we && ws == 2'd1) m_cause[9:8] = wd[9:8];
    end
    #3;
    exc_req = 0; rfe = 0; wr_en = 0;
    check_all(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    do_reset(1'b0);
    // R5 R4 R3: entry without delay, boot vector
    step("R3 R4 R5 nodelay rom", 1, 5'd8, 2'd0, 32'h0000_0100, 0, 0, 0, 0, 0);
    step("R5 pulse ends", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    do_reset(1'b1);
    // R4 R5: delay slot, RAM vector
    step("R4 R5 delay ram", 1, 5'd9, 2'd2, 32'h8001_0008, 0, 0, 0, 0, 0);
    // R9: pending mirrored, cause 9:8 written, then R3 keeps 10:8
    step("R9 mirror", 0, 0, 0, 0, 0, 1, 1, 2'd1, 32'hFFFF_FFFF);
    step("R3 keep 10:8", 1, 5'd8, 2'd1, 32'h0000_2000, 0, 0, 0, 0, 0);
    // R11: writes to epc and id ignored
    step("R11 epc write", 0, 0, 0, 0, 0, 0, 1, 2'd2, 32'h1234_5678);
    step("R11 id write", 0, 0, 0, 0, 0, 0, 1, 2'd3, 32'h1234_5678);
    // R6 R7: three nested entries then three returns
    step("R6 setup", 0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h1040_0003);
    for (int i = 0; i < 3; i++)
      step("R6 nest", 1, 5'd9, 2'd0, 32'h100 + i * 4, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++)
      step("R7 pop", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R10: collisions
    step("R10 exc+rfe", 1, 5'd8, 2'd0, 32'h40, 1, 0, 0, 0, 0);
    step("R10 exc+wr", 1, 5'd8, 2'd0, 32'h44, 0, 0, 1, 2'd0, 32'h0000_0000);
    step("R10 wr+rfe", 0, 0, 0, 0, 1, 0, 1, 2'd0, 32'h1040_0401);
    // R8: interrupt entry with code 0
    step("R8 irq", 0, 0, 2'd0, 32'h500, 0, 1, 0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("R10 random", (r[1:0] == 0), r[6:2], r[8:7], $urandom, (r[10:9] == 0),
           r[11], (r[13:12] == 0), r[15:14], {r[31:16] ^ 16'h1040, r[15:0] | 16'h0400});
    end
    finish_run();
  end
endmodule